// File: doc/BRIEF.md
# Critical-Word-First Block Memory Responder

This block sits on the memory side of a command/response memory interface and serves each command from a memory array of its own, organised in fixed-size blocks. A command header carries a message kind, a byte address, a size code and an opaque tag field called the payload. A write command also carries data. The responder takes one command at a time over a valid/ready handshake. It performs the access and then returns a response that repeats the header, including the payload bit for bit. The response is held until the consumer takes it.

Cached commands work on whole blocks. A cached read returns the complete block that holds the address. The word containing the address comes first, at the least significant end, and the following words continue upward and wrap around the end of the block. A cached write replaces the whole block. Uncached commands touch only the naturally aligned run of bytes that the size code names. A byte-enable mask is built from the address and the size. An uncached command that is misaligned, or larger than a block, is refused with an error flag and leaves memory untouched.

Top module: `memresp_top`

## Requirements
- R1: After reset, `cmdReady` is 1 and `respValid` is 0. `cmdReady` is 1 only while no command is in progress, so while `respValid` is 1, `cmdReady` is 0. A command is taken on a clock edge where `cmdValid` and `cmdReady` are both 1.
- R2: While `respValid` is 1 and `respReady` is 0, `respValid` stays 1 and every response field stays unchanged. The response is consumed on an edge where both are 1.
- R3: Each response returns the kind, address, size code and payload of its own command unchanged.
- R4: Message kind 0 is a cached read. The block index is address bits [8:5] and the byte offset is bits [4:0], with 32-byte blocks of 8-byte words. The response data holds all 32 bytes. Data bits [63:0] carry the word selected by address bits [4:3], and each higher 64-bit lane carries the next word, modulo 4.
- R5: Message kind 1 is a cached write. It replaces the addressed block: block byte i takes data bits [8i+7:8i]. The byte offset and the size code have no effect. The response data is 0.
- R6: Message kind 2 is an uncached read. Size code s means 2^s bytes, for s from 0 to 7. The bytes from the address upward appear from data bit 0 upward, and all higher bits are 0.
- R7: Message kind 3 is an uncached write. It updates only the 2^s addressed bytes, taking them from the low bytes of the data in order. All other bytes of the block keep their value. The response data is 0.
- R8: An uncached command is an error if its address is not a multiple of 2^s, or if 2^s is more than 32. It returns `respError`=1 and data 0, and it changes no memory. Cached commands never return an error.
- R9: After reset every byte of the memory reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Responder can take a command |
| cmdType | input | 2 | Message kind: 0 cached read, 1 cached write, 2 uncached read, 3 uncached write |
| cmdAddr | input | 12 | Byte address |
| cmdSize | input | 3 | Size code, 2^code bytes |
| cmdPayload | input | 8 | Opaque tag |
| cmdData | input | 256 | Write data |
| respValid | output | 1 | Response present |
| respReady | input | 1 | Consumer takes the response |
| respType | output | 2 | Echoed message kind |
| respAddr | output | 12 | Echoed address |
| respSize | output | 3 | Echoed size code |
| respPayload | output | 8 | Echoed tag |
| respError | output | 1 | Uncached command refused |
| respData | output | 256 | Read data |

## Verification
The hardest case to reach from the ports is a refused uncached write that lands on a block already holding non-zero data. Only a later read of that block can show that the block was left alone. The stimulus therefore fills blocks with random cached writes, mixes in misaligned and oversized uncached writes, and reads the same blocks back through both read kinds. Every result is compared against a byte-level model. Directed cases cover the wrap order of a cached read at each word offset with known word patterns, and a partial write at the last bytes of a block.

// File: rtl/memresp_pkg.sv
package memresp_pkg;

  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {
    MSG_RD    = 2'd0,
    MSG_WR    = 2'd1,
    MSG_UC_RD = 2'd2,
    MSG_UC_WR = 2'd3
  } msgKind_e;

  typedef struct packed {
    logic loadCmd;
    logic execute;
  } dpStrobe_t;

endpackage

// File: rtl/memresp_ctrl.sv
module memresp_ctrl
  import memresp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      respReady,
  output logic      cmdReady,
  output logic      respValid,
  output dpStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_RESP} state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (cmdValid)  stateNext = ST_EXEC;
      ST_EXEC:                stateNext = ST_RESP;
      ST_RESP: if (respReady) stateNext = ST_IDLE;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdReady       = (state == ST_IDLE);
  assign respValid      = (state == ST_RESP);
  assign strobe.loadCmd = (state == ST_IDLE) && cmdValid;
  assign strobe.execute = (state == ST_EXEC);

endmodule

// File: rtl/memresp_datapath.sv
module memresp_datapath
  import memresp_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAYLOAD_W   = 8,
  parameter int BLOCK_BYTES = 32,
  parameter int WORD_BYTES  = 8,
  parameter int NUM_BLOCKS  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic [1:0]               cmdType,
  input  logic [ADDR_W-1:0]        cmdAddr,
  input  logic [SIZE_W-1:0]        cmdSize,
  input  logic [PAYLOAD_W-1:0]     cmdPayload,
  input  logic [BLOCK_BYTES*8-1:0] cmdData,
  output logic [1:0]               respType,
  output logic [ADDR_W-1:0]        respAddr,
  output logic [SIZE_W-1:0]        respSize,
  output logic [PAYLOAD_W-1:0]     respPayload,
  output logic                     respError,
  output logic [BLOCK_BYTES*8-1:0] respData
);

  localparam int BLOCK_BITS = BLOCK_BYTES * 8;
  localparam int WORD_BITS  = WORD_BYTES * 8;
  localparam int OFF_W      = $clog2(BLOCK_BYTES);
  localparam int WOFF_W     = $clog2(WORD_BYTES);
  localparam int WSEL_W     = OFF_W - WOFF_W;
  localparam int IDX_W      = $clog2(NUM_BLOCKS);
  localparam int NB_W       = 2 ** SIZE_W;

  // captured command
  logic [1:0]            typeQ;
  logic [ADDR_W-1:0]     addrQ;
  logic [SIZE_W-1:0]     sizeQ;
  logic [PAYLOAD_W-1:0]  payloadQ;
  logic [BLOCK_BITS-1:0] dataQ;

  // response registers
  logic [BLOCK_BITS-1:0] respDataQ;
  logic                  respErrQ;

  logic [BLOCK_BITS-1:0] memArr [NUM_BLOCKS];

  logic [IDX_W-1:0]  blkIdx;
  logic [OFF_W-1:0]  byteOff;
  logic [WSEL_W-1:0] wordSel;
  logic [NB_W-1:0]   nBytes;
  logic              isUncached, isWrite, tooBig, misAligned, ucErr;

  assign blkIdx     = addrQ[OFF_W +: IDX_W];
  assign byteOff    = addrQ[OFF_W-1:0];
  assign wordSel    = addrQ[OFF_W-1:WOFF_W];
  assign nBytes     = NB_W'(1) << sizeQ;
  assign isUncached = typeQ[1];
  assign isWrite    = typeQ[0];
  assign tooBig     = int'(nBytes) > BLOCK_BYTES;
  assign misAligned = (NB_W'(byteOff) & (nBytes - NB_W'(1))) != '0;
  assign ucErr      = isUncached && (tooBig || misAligned);

  logic [BLOCK_BITS-1:0]   blkRd;
  logic [2*BLOCK_BITS-1:0] dblBlk;
  logic [BLOCK_BITS-1:0]   rotData;
  logic [BLOCK_BITS-1:0]   ucShift;
  logic [BLOCK_BITS-1:0]   wrShift;
  logic [BLOCK_BITS-1:0]   ucRdData;
  logic [BLOCK_BITS-1:0]   ucWrBlk;
  logic [BLOCK_BYTES-1:0]  byteEn;
  logic [BLOCK_BYTES-1:0]  lowKeep;

  assign blkRd   = memArr[blkIdx];
  // rotate right by whole words so the addressed word lands at bit 0
  assign dblBlk  = {blkRd, blkRd} >> (int'(wordSel) * WORD_BITS);
  assign rotData = dblBlk[BLOCK_BITS-1:0];
  assign ucShift = blkRd >> (int'(byteOff) * 8);
  assign wrShift = dataQ << (int'(byteOff) * 8);

  for (genvar gB = 0; gB < BLOCK_BYTES; gB++) begin : g_byte
    assign byteEn[gB]  = (gB >= int'(byteOff)) &&
                         (gB < int'(byteOff) + int'(nBytes));
    assign lowKeep[gB] = gB < int'(nBytes);
    assign ucRdData[gB*8 +: 8] = lowKeep[gB] ? ucShift[gB*8 +: 8] : 8'h00;
    assign ucWrBlk[gB*8 +: 8]  = byteEn[gB] ? wrShift[gB*8 +: 8]
                                            : blkRd[gB*8 +: 8];
  end

  logic [BLOCK_BITS-1:0] respDataNext;
  always_comb begin
    respDataNext = '0;
    if (!ucErr) begin
      unique case (msgKind_e'(typeQ))
        MSG_RD:    respDataNext = rotData;
        MSG_UC_RD: respDataNext = ucRdData;
        default:   respDataNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      typeQ     <= '0;
      addrQ     <= '0;
      sizeQ     <= '0;
      payloadQ  <= '0;
      dataQ     <= '0;
      respDataQ <= '0;
      respErrQ  <= 1'b0;
    end else begin
      if (strobe.loadCmd) begin
        typeQ    <= cmdType;
        addrQ    <= cmdAddr;
        sizeQ    <= cmdSize;
        payloadQ <= cmdPayload;
        dataQ    <= cmdData;
      end
      if (strobe.execute) begin
        respDataQ <= respDataNext;
        respErrQ  <= ucErr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BLOCKS; b++) memArr[b] <= '0;
    end else if (strobe.execute && isWrite && !ucErr) begin
      memArr[blkIdx] <= isUncached ? ucWrBlk : dataQ;
    end
  end

  assign respType    = typeQ;
  assign respAddr    = addrQ;
  assign respSize    = sizeQ;
  assign respPayload = payloadQ;
  assign respError   = respErrQ;
  assign respData    = respDataQ;

endmodule

// File: rtl/memresp_top.sv
module memresp_top
  import memresp_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAYLOAD_W   = 8,
  parameter int BLOCK_BYTES = 32,
  parameter int WORD_BYTES  = 8,
  parameter int NUM_BLOCKS  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  output logic                     cmdReady,
  input  logic [1:0]               cmdType,
  input  logic [ADDR_W-1:0]        cmdAddr,
  input  logic [2:0]               cmdSize,
  input  logic [PAYLOAD_W-1:0]     cmdPayload,
  input  logic [BLOCK_BYTES*8-1:0] cmdData,
  output logic                     respValid,
  input  logic                     respReady,
  output logic [1:0]               respType,
  output logic [ADDR_W-1:0]        respAddr,
  output logic [2:0]               respSize,
  output logic [PAYLOAD_W-1:0]     respPayload,
  output logic                     respError,
  output logic [BLOCK_BYTES*8-1:0] respData
);

  dpStrobe_t strobe;

  memresp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .respReady (respReady),
    .cmdReady  (cmdReady),
    .respValid (respValid),
    .strobe    (strobe)
  );

  memresp_datapath #(
    .ADDR_W      (ADDR_W),
    .PAYLOAD_W   (PAYLOAD_W),
    .BLOCK_BYTES (BLOCK_BYTES),
    .WORD_BYTES  (WORD_BYTES),
    .NUM_BLOCKS  (NUM_BLOCKS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdType     (cmdType),
    .cmdAddr     (cmdAddr),
    .cmdSize     (cmdSize),
    .cmdPayload  (cmdPayload),
    .cmdData     (cmdData),
    .respType    (respType),
    .respAddr    (respAddr),
    .respSize    (respSize),
    .respPayload (respPayload),
    .respError   (respError),
    .respData    (respData)
  );

endmodule

// File: rtl/memresp_checker.sv
module memresp_checker #(
  parameter int ADDR_W      = 12,
  parameter int PAYLOAD_W   = 8,
  parameter int BLOCK_BYTES = 32
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     cmdValid,
  input logic                     cmdReady,
  input logic [1:0]               cmdType,
  input logic [ADDR_W-1:0]        cmdAddr,
  input logic [PAYLOAD_W-1:0]     cmdPayload,
  input logic                     respValid,
  input logic                     respReady,
  input logic [1:0]               respType,
  input logic [ADDR_W-1:0]        respAddr,
  input logic [PAYLOAD_W-1:0]     respPayload,
  input logic                     respError,
  input logic [BLOCK_BYTES*8-1:0] respData
);

  a_r1_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !cmdReady);

  a_r2_resp_held: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> (respValid && $stable(respData) &&
      $stable(respError) && $stable(respPayload) && $stable(respAddr)));

  a_r3_payload_echo: assert property (@(posedge clk) disable iff (!rstN)
    $rose(respValid) |-> ($past(cmdValid && cmdReady, 2) &&
      respPayload == $past(cmdPayload, 2) && respAddr == $past(cmdAddr, 2) &&
      respType == $past(cmdType, 2)));

  a_r8_err_only_uncached: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respError) |-> (respType[1] && respData == '0));

  a_r5_r7_write_no_data: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respType[0]) |-> respData == '0);

endmodule

bind memresp_top memresp_checker #(
  .ADDR_W      (ADDR_W),
  .PAYLOAD_W   (PAYLOAD_W),
  .BLOCK_BYTES (BLOCK_BYTES)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdReady    (cmdReady),
  .cmdType     (cmdType),
  .cmdAddr     (cmdAddr),
  .cmdPayload  (cmdPayload),
  .respValid   (respValid),
  .respReady   (respReady),
  .respType    (respType),
  .respAddr    (respAddr),
  .respPayload (respPayload),
  .respError   (respError),
  .respData    (respData)
);

// File: tb/memresp_top_tb.sv
`timescale 1ns/1ps
module memresp_top_tb;

  localparam int ADDR_W = 12;
  localparam int PAY_W  = 8;
  localparam int BB     = 32;
  localparam int WB     = 8;
  localparam int NB     = 16;
  localparam int BITS   = BB * 8;
  localparam int OFF_W  = 5;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [1:0] cmdType = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [2:0] cmdSize = '0;
  logic [PAY_W-1:0] cmdPayload = '0;
  logic [BITS-1:0] cmdData = '0;
  logic respValid;
  logic respReady = 1'b0;
  logic [1:0] respType;
  logic [ADDR_W-1:0] respAddr;
  logic [2:0] respSize;
  logic [PAY_W-1:0] respPayload;
  logic respError;
  logic [BITS-1:0] respData;

  always #2.5 clk = ~clk;

  memresp_top u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdType(cmdType), .cmdAddr(cmdAddr), .cmdSize(cmdSize),
    .cmdPayload(cmdPayload), .cmdData(cmdData), .respValid(respValid),
    .respReady(respReady), .respType(respType), .respAddr(respAddr),
    .respSize(respSize), .respPayload(respPayload), .respError(respError),
    .respData(respData)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] refMem [NB*BB];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [BITS-1:0] act, input logic [BITS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit expErr(input logic [1:0] t, input logic [ADDR_W-1:0] a,
                                input logic [2:0] s);
    int n = 1 << s;
    int off = int'(a[OFF_W-1:0]);
    return t[1] && (n > BB || (off % n) != 0);
  endfunction

  function automatic logic [BITS-1:0] expData(input logic [1:0] t,
      input logic [ADDR_W-1:0] a, input logic [2:0] s);
    logic [BITS-1:0] r = '0;
    int base = int'(a[OFF_W +: IDX_W]) * BB;
    int off  = int'(a[OFF_W-1:0]);
    int w    = off / WB;
    int n    = 1 << s;
    if (expErr(t, a, s)) return r;
    if (t == 2'd0)
      for (int i = 0; i < BB; i++) r[8*i +: 8] = refMem[base + ((w*WB + i) % BB)];
    else if (t == 2'd2)
      for (int i = 0; i < n; i++) r[8*i +: 8] = refMem[base + off + i];
    return r;
  endfunction

  function automatic void applyRef(input logic [1:0] t, input logic [ADDR_W-1:0] a,
      input logic [2:0] s, input logic [BITS-1:0] d);
    int base = int'(a[OFF_W +: IDX_W]) * BB;
    int off  = int'(a[OFF_W-1:0]);
    int n    = 1 << s;
    if (expErr(t, a, s)) return;
    if (t == 2'd1)
      for (int i = 0; i < BB; i++) refMem[base + i] = d[8*i +: 8];
    else if (t == 2'd3)
      for (int i = 0; i < n; i++) refMem[base + off + i] = d[8*i +: 8];
  endfunction

  function automatic string reqOf(input logic [1:0] t, input bit e);
    if (e) return "R8";
    case (t)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  logic [BITS-1:0] lastData;

  task automatic doCmd(input logic [1:0] t, input logic [ADDR_W-1:0] a,
                       input logic [2:0] s, input logic [BITS-1:0] d);
    logic [PAY_W-1:0] pay = PAY_W'($urandom);
    bit e = expErr(t, a, s);
    logic [BITS-1:0] ed = expData(t, a, s);
    int hold = int'($urandom % 3);
    @(negedge clk);
    cmdType = t; cmdAddr = a; cmdSize = s; cmdPayload = pay; cmdData = d;
    cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    cmdData = BITS'({$urandom, $urandom});
    while (!respValid) begin
      // R1: no new command taken while one is in progress
      chk(!cmdReady || respValid, "R1", "ready while busy", BITS'(cmdReady), '0);
      @(negedge clk);
    end
    chk(!cmdReady, "R1", "ready during response", BITS'(cmdReady), '0);
    chk(respType == t && respAddr == a && respSize == s && respPayload == pay,
        "R3", "header echo", BITS'({respType, respAddr, respSize, respPayload}),
        BITS'({t, a, s, pay}));
    chk(respError == e, "R8", "error flag", BITS'(respError), BITS'(e));
    chk(respData == ed, reqOf(t, e), "data", respData, ed);
    lastData = respData;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(respValid && respData == ed && respPayload == pay, "R2",
          "held response", respData, ed);
    end
    respReady = 1'b1;
    @(negedge clk);
    respReady = 1'b0;
    applyRef(t, a, s, d);
  endtask

  function automatic logic [BITS-1:0] rndData();
    logic [BITS-1:0] r;
    for (int i = 0; i < BITS/32; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [BITS-1:0] pat;
    void'($urandom(32'd20240));
    for (int i = 0; i < NB*BB; i++) refMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady && !respValid, "R1", "reset state",
        BITS'({cmdReady, respValid}), BITS'(2'b10));

    // R9: memory reads zero after reset
    doCmd(2'd0, 12'h0A8, 3'd0, '0);
    chk(lastData == '0, "R9", "reset memory", lastData, '0);

    // R4: wrap order with words A..D, read at each word offset
    pat = {64'hDDDD_DDDD_DDDD_DDDD, 64'hCCCC_CCCC_CCCC_CCCC,
           64'hBBBB_BBBB_BBBB_BBBB, 64'hAAAA_AAAA_AAAA_AAAA};
    doCmd(2'd1, 12'h047, 3'd2, pat);
    doCmd(2'd0, 12'h050, 3'd5, '0);
    chk(lastData == {pat[127:0], pat[255:128]}, "R4", "wrap at 0x10",
        lastData, {pat[127:0], pat[255:128]});
    doCmd(2'd0, 12'h040, 3'd5, '0);
    chk(lastData == pat, "R4", "no wrap at 0x00", lastData, pat);
    doCmd(2'd0, 12'h05F, 3'd0, '0);
    doCmd(2'd0, 12'h04B, 3'd3, '0);

    // R7: partial write at the block end, then readback
    doCmd(2'd3, 12'h05C, 3'd2, BITS'(32'h1234_5678));
    doCmd(2'd2, 12'h058, 3'd3, '0);
    doCmd(2'd3, 12'h040, 3'd5, rndData());

    // R8: oversized, misaligned, then readback shows memory unchanged
    doCmd(2'd3, 12'h040, 3'd6, rndData());
    doCmd(2'd3, 12'h042, 3'd2, rndData());
    doCmd(2'd2, 12'h043, 3'd1, '0);
    doCmd(2'd2, 12'h000, 3'd7, '0);
    doCmd(2'd0, 12'h040, 3'd0, '0);

    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic [1:0] t = 2'($urandom);
      logic [ADDR_W-1:0] a = ADDR_W'($urandom);
      logic [2:0] s = 3'($urandom % 7);
      if (t[1] && ($urandom % 4) != 0) a = a & ~(ADDR_W'((1 << s) - 1));
      doCmd(t, a, s, rndData());
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule